// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects three interrupt sources from a graphics engine: a render frame has finished, a binning flush has finished, and the binner has run out of overflow memory. It raises one level interrupt line toward the host. Software sees a pending word that it acknowledges by writing ones. The enable mask is never written directly. One register turns mask bits on and a second turns them off, and either register reads back the current mask.

The frame and flush sources arrive as one-cycle pulses. Each pulse latches a pending bit, which stays set until software acknowledges it. The out-of-memory source is different. It comes from an internal condition flag that is set at reset, because no overflow pool exists yet. The flag is set again whenever the engine signals that the pool is exhausted. While the flag is set, the pending bit comes back at once after every acknowledge. To recover, software writes the pool base and a nonzero pool length, then acknowledges the pending bit and re-enables the source.

The register port is a plain synchronous interface. Writes take effect at the clock edge and read data comes back combinationally in the same cycle. The word offsets are: 0 pending, 1 enable-set, 2 enable-clear, 3 pool base, 4 pool length. Every other offset reads as zero.

Top module: `gpu_irq_ctrl`

## Requirements
- R1: After reset the enable mask is 0, pending bits 0 (frame) and 1 (flush) are 0, pending bit 2 (out-of-memory) is 1, the interrupt output is 0, and both pool registers read 0.
- R2: A pulse on the frame-done input sets pending bit 0. A pulse on the flush-done input sets pending bit 1. Each bit stays set until it is acknowledged.
- R3: A write to the pending word at offset 0 clears every pending bit whose data bit is 1. Pending bits whose data bit is 0 are unchanged.
- R4: A write to the enable-set word at offset 1 sets every mask bit whose data bit is 1. Zero data bits leave their mask bits unchanged.
- R5: A write to the enable-clear word at offset 2 clears every mask bit whose data bit is 1. Zero data bits leave their mask bits unchanged.
- R6: A read of offset 1 returns the 3-bit mask in bits 2..0, and so does a read of offset 2. Bits 31..3 always read 0, and writes to those bits have no effect.
- R7: While the out-of-memory condition holds, pending bit 2 is set again right after an acknowledge. Once a nonzero length has been written and the condition has cleared, an acknowledge of bit 2 keeps it at 0.
- R8: Writing a length of 0 leaves the out-of-memory condition set. An exhaust pulse sets the condition again, and pending bit 2 reads 1 two clock edges after that pulse.
- R9: The interrupt output equals the OR of (pending AND mask), registered once. It changes one clock edge after the pending or mask change that causes it.
- R10: If an event pulse and an acknowledge of the same pending bit arrive in the same cycle, the bit stays set.
- R11: The pool base (offset 3) and pool length (offset 4) read back the last value written to them. Offsets 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; 0 when not selected |
| ev_frame_done | input | 1 | One-cycle pulse: render frame finished |
| ev_flush_done | input | 1 | One-cycle pulse: binning flush finished |
| ev_pool_exhausted | input | 1 | One-cycle pulse: binner used up its overflow pool |
| irq | output | 1 | Level interrupt request |

## Verification
All register writes take effect at the clock edge where they are presented. Read data follows the address in the same cycle. The bench therefore drives at the falling edge and samples reads just after the next falling edge, once the write edge has passed.

An event pulse appears in the pending word one edge later. An exhaust pulse needs two edges: one to set the condition flag and one more for the pending bit, so the bench reads status after a spare cycle. The interrupt line lags pending and mask by one more register. Each irq check therefore samples both the cycle right after the causing write, where the old level must still hold, and the cycle after that, where the new level must appear.

// File: rtl/gpu_irq_pkg.sv
// Shared constants for the graphics interrupt controller.
// Assumes: source bit positions are fixed by the software view of the pending word.
package gpu_irq_pkg;
    localparam int unsigned SRC_COUNT = 3;
    localparam int unsigned SRC_FRAME = 0;
    localparam int unsigned SRC_FLUSH = 1;
    localparam int unsigned SRC_OOM   = 2;

    typedef enum logic [2:0] {
        OFS_PENDING   = 3'd0,
        OFS_EN_SET    = 3'd1,
        OFS_EN_CLR    = 3'd2,
        OFS_POOL_BASE = 3'd3,
        OFS_POOL_LEN  = 3'd4
    } reg_ofs_e;
endpackage

// File: rtl/gpu_irq_decode.sv
// Write-strobe decoder for the register port.
// Assumes: one access per cycle; reads have no side effects.
module gpu_irq_decode
    import gpu_irq_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    output logic          we_pending_o,
    output logic          we_en_set_o,
    output logic          we_en_clr_o,
    output logic          we_base_o,
    output logic          we_len_o
);
    logic wr_cycle;

    // Qualify a write cycle, then match each mapped offset.
    always_comb begin
        wr_cycle     = sel_i && wr_i;
        we_pending_o = wr_cycle && (addr_i == AW'(OFS_PENDING));
        we_en_set_o  = wr_cycle && (addr_i == AW'(OFS_EN_SET));
        we_en_clr_o  = wr_cycle && (addr_i == AW'(OFS_EN_CLR));
        we_base_o    = wr_cycle && (addr_i == AW'(OFS_POOL_BASE));
        we_len_o     = wr_cycle && (addr_i == AW'(OFS_POOL_LEN));
    end
endmodule

// File: rtl/gpu_irq_pending.sv
// Pending bank: one sticky bit per source, set by its source and cleared by
// a write-one acknowledge. A set in the same cycle beats the acknowledge.
// Assumes: level sources drive set_i for as long as their condition holds.
module gpu_irq_pending #(
    parameter int unsigned N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         ack_we_i,
    input  logic [N-1:0] ack_bits_i,
    output logic [N-1:0] pend_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        // Hold one pending flag; the source has priority over acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= RST_VAL[i];
            else if (set_i[i])
                bit_q <= 1'b1;
            else if (ack_we_i && ack_bits_i[i])
                bit_q <= 1'b0;
        end
        assign pend_o[i] = bit_q;
    end
endmodule

// File: rtl/gpu_irq_mask.sv
// Enable mask changed only by write-one-to-set and write-one-to-clear strobes.
// Assumes: set and clear strobes are never active in the same cycle.
module gpu_irq_mask #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] bits_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_q;

    // Apply the selected bit-wise set or clear to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (set_we_i)
            mask_q <= mask_q | bits_i;
        else if (clr_we_i)
            mask_q <= mask_q & ~bits_i;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/gpu_irq_pool.sv
// Overflow pool registers and the out-of-memory condition flag.
// The flag starts set, because no pool exists after reset. A nonzero length
// write clears it; an exhaust pulse sets it and wins over a same-cycle write.
module gpu_irq_pool #(
    parameter int unsigned BASE_W = 32,
    parameter int unsigned LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we_i,
    input  logic              len_we_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              exhaust_i,
    output logic [BASE_W-1:0] base_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              oom_o
);
    logic [BASE_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic              oom_q;

    // Capture the pool base address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (base_we_i)
            base_q <= base_i;
    end

    // Capture the pool length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= '0;
        else if (len_we_i)
            len_q <= len_i;
    end

    // Track whether the binner currently lacks overflow memory.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oom_q <= 1'b1;
        else if (exhaust_i)
            oom_q <= 1'b1;
        else if (len_we_i && (len_i != '0))
            oom_q <= 1'b0;
    end

    assign base_o = base_q;
    assign len_o  = len_q;
    assign oom_o  = oom_q;
endmodule

// File: rtl/gpu_irq_ctrl.sv
// Top of the graphics interrupt controller: pending bank, enable mask,
// overflow pool registers, read mux and a registered interrupt line.
// Assumes: POOL_BASE_W and POOL_LEN_W are no larger than DATA_W; the event
// inputs are synchronous one-cycle pulses.
module gpu_irq_ctrl
    import gpu_irq_pkg::*;
#(
    parameter int unsigned REG_ADDR_W  = 3,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned POOL_BASE_W = 32,
    parameter int unsigned POOL_LEN_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  ev_frame_done,
    input  logic                  ev_flush_done,
    input  logic                  ev_pool_exhausted,
    output logic                  irq
);
    localparam int unsigned N = SRC_COUNT;
    localparam logic [N-1:0] PEND_RST = N'(1) << SRC_OOM;

    logic we_pending, we_en_set, we_en_clr, we_base, we_len;
    logic [N-1:0]           src_set;
    logic [N-1:0]           pend_q;
    logic [N-1:0]           mask_q;
    logic [POOL_BASE_W-1:0] base_q;
    logic [POOL_LEN_W-1:0]  len_q;
    logic                   oom_q;
    logic                   irq_q;

    gpu_irq_decode #(.AW(REG_ADDR_W)) u_decode (
        .sel_i        (bus_sel),
        .wr_i         (bus_wr),
        .addr_i       (bus_addr),
        .we_pending_o (we_pending),
        .we_en_set_o  (we_en_set),
        .we_en_clr_o  (we_en_clr),
        .we_base_o    (we_base),
        .we_len_o     (we_len)
    );

    // Route each source to its pending bit position.
    always_comb begin
        src_set            = '0;
        src_set[SRC_FRAME] = ev_frame_done;
        src_set[SRC_FLUSH] = ev_flush_done;
        src_set[SRC_OOM]   = oom_q;
    end

    gpu_irq_pending #(.N(N), .RST_VAL(PEND_RST)) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (src_set),
        .ack_we_i   (we_pending),
        .ack_bits_i (bus_wdata[N-1:0]),
        .pend_o     (pend_q)
    );

    gpu_irq_mask #(.N(N)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we_i (we_en_set),
        .clr_we_i (we_en_clr),
        .bits_i   (bus_wdata[N-1:0]),
        .mask_o   (mask_q)
    );

    gpu_irq_pool #(.BASE_W(POOL_BASE_W), .LEN_W(POOL_LEN_W)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_we_i (we_base),
        .len_we_i  (we_len),
        .base_i    (bus_wdata[POOL_BASE_W-1:0]),
        .len_i     (bus_wdata[POOL_LEN_W-1:0]),
        .exhaust_i (ev_pool_exhausted),
        .base_o    (base_q),
        .len_o     (len_q),
        .oom_o     (oom_q)
    );

    // Select read data for the addressed word; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                REG_ADDR_W'(OFS_PENDING):   bus_rdata = DATA_W'(pend_q);
                REG_ADDR_W'(OFS_EN_SET):    bus_rdata = DATA_W'(mask_q);
                REG_ADDR_W'(OFS_EN_CLR):    bus_rdata = DATA_W'(mask_q);
                REG_ADDR_W'(OFS_POOL_BASE): bus_rdata = DATA_W'(base_q);
                REG_ADDR_W'(OFS_POOL_LEN):  bus_rdata = DATA_W'(len_q);
                default:                    bus_rdata = '0;
            endcase
        end
    end

    // Register the combined request so the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(pend_q & mask_q);
    end

    assign irq = irq_q;
endmodule

// File: rtl/gpu_irq_ctrl_chk.sv
// Property checker for gpu_irq_ctrl, attached by bind.
// Assumes: it observes the top's ports plus its pending, mask and condition state.
module gpu_irq_ctrl_chk
    import gpu_irq_pkg::*;
#(
    parameter int unsigned AW = 3,
    parameter int unsigned DW = 32,
    parameter int unsigned N  = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          ev_frame_done,
    input logic          ev_flush_done,
    input logic          ev_pool_exhausted,
    input logic          irq,
    input logic [N-1:0]  pend,
    input logic [N-1:0]  mask,
    input logic          oom_cond
);
    logic wr_pend, wr_set, wr_clr;
    assign wr_pend = bus_sel && bus_wr && (bus_addr == AW'(OFS_PENDING));
    assign wr_set  = bus_sel && bus_wr && (bus_addr == AW'(OFS_EN_SET));
    assign wr_clr  = bus_sel && bus_wr && (bus_addr == AW'(OFS_EN_CLR));

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (mask == '0 && !pend[SRC_FRAME] && !pend[SRC_FLUSH]
                    && pend[SRC_OOM] && oom_cond && !irq));

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flush_done |=> pend[SRC_FLUSH]);

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && bus_wdata[SRC_FLUSH] && !ev_flush_done) |=> !pend[SRC_FLUSH]);

    p_enable_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && bus_wdata[SRC_FRAME]) |=> mask[SRC_FRAME]);

    p_enable_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && bus_wdata[SRC_OOM]) |=> !mask[SRC_OOM]);

    p_oom_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oom_cond |=> pend[SRC_OOM]);

    p_exhaust_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pool_exhausted |=> oom_cond);

    p_irq_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|(pend & mask))));

    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame_done && wr_pend && bus_wdata[SRC_FRAME]) |=> pend[SRC_FRAME]);
endmodule

bind gpu_irq_ctrl gpu_irq_ctrl_chk #(
    .AW (REG_ADDR_W),
    .DW (DATA_W),
    .N  (gpu_irq_pkg::SRC_COUNT)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .bus_sel           (bus_sel),
    .bus_wr            (bus_wr),
    .bus_addr          (bus_addr),
    .bus_wdata         (bus_wdata),
    .ev_frame_done     (ev_frame_done),
    .ev_flush_done     (ev_flush_done),
    .ev_pool_exhausted (ev_pool_exhausted),
    .irq               (irq),
    .pend              (pend_q),
    .mask              (mask_q),
    .oom_cond          (oom_q)
);

// File: tb/gpu_irq_ctrl_tb.sv
module gpu_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_PU = 2'd2;

    localparam logic [2:0] A_ST = 3'd0;
    localparam logic [2:0] A_ES = 3'd1;
    localparam logic [2:0] A_EC = 3'd2;
    localparam logic [2:0] A_BA = 3'd3;
    localparam logic [2:0] A_LN = 3'd4;
    localparam logic [2:0] A_UN = 3'd7;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 36;
    // Pulse data: bit0 frame, bit1 flush, bit2 exhaust.
    localparam vec_t VEC [NVEC] = '{
        '{OP_RD, A_ST, 32'h4,        4'd1},  // R1 reset pending
        '{OP_RD, A_ES, 32'h0,        4'd1},  // R1 mask
        '{OP_RD, A_EC, 32'h0,        4'd1},
        '{OP_PU, A_ST, 32'h1,        4'd2},  // R2 frame pulse
        '{OP_RD, A_ST, 32'h5,        4'd2},
        '{OP_PU, A_ST, 32'h2,        4'd2},  // R2 flush pulse
        '{OP_RD, A_ST, 32'h7,        4'd2},
        '{OP_WR, A_ST, 32'h1,        4'd3},  // R3 ack frame
        '{OP_RD, A_ST, 32'h6,        4'd3},
        '{OP_WR, A_ST, 32'h0,        4'd3},  // R3 zero ack
        '{OP_RD, A_ST, 32'h6,        4'd3},
        '{OP_WR, A_ES, 32'hFFFFFFFA, 4'd4},  // R4 set
        '{OP_RD, A_ES, 32'h2,        4'd4},
        '{OP_WR, A_ES, 32'h5,        4'd4},
        '{OP_RD, A_EC, 32'h7,        4'd6},  // R6 clear word reads mask
        '{OP_WR, A_EC, 32'h2,        4'd5},  // R5 clear
        '{OP_RD, A_ES, 32'h5,        4'd5},
        '{OP_WR, A_EC, 32'hFFFFFFF8, 4'd5},  // R5 zero low bits ignored
        '{OP_RD, A_EC, 32'h5,        4'd5},
        '{OP_WR, A_ST, 32'h4,        4'd7},  // R7 ack while condition holds
        '{OP_RD, A_ST, 32'h6,        4'd7},
        '{OP_WR, A_LN, 32'h0,        4'd8},  // R8 zero length
        '{OP_WR, A_ST, 32'h4,        4'd8},
        '{OP_RD, A_ST, 32'h6,        4'd8},
        '{OP_WR, A_BA, 32'h1000,     4'd11}, // R11 pool regs
        '{OP_WR, A_LN, 32'h40000,    4'd11},
        '{OP_RD, A_LN, 32'h40000,    4'd11},
        '{OP_RD, A_BA, 32'h1000,     4'd11},
        '{OP_WR, A_ST, 32'h4,        4'd7},  // R7 ack after new pool
        '{OP_RD, A_ST, 32'h2,        4'd7},
        '{OP_PU, A_ST, 32'h4,        4'd8},  // R8 exhaust
        '{OP_RD, A_ST, 32'h6,        4'd8},
        '{OP_WR, A_UN, 32'hFFFFFFFF, 4'd11}, // R11 unmapped write
        '{OP_RD, A_UN, 32'h0,        4'd11},
        '{OP_RD, A_ST, 32'h6,        4'd11},
        '{OP_RD, A_ES, 32'h5,        4'd6}   // R6 upper bits zero
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_frame_done = 1'b0;
    logic        ev_flush_done = 1'b0;
    logic        ev_pool_exhausted = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpu_irq_ctrl u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .bus_sel           (bus_sel),
        .bus_wr            (bus_wr),
        .bus_addr          (bus_addr),
        .bus_wdata         (bus_wdata),
        .bus_rdata         (bus_rdata),
        .ev_frame_done     (ev_frame_done),
        .ev_flush_done     (ev_flush_done),
        .ev_pool_exhausted (ev_pool_exhausted),
        .irq               (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] bits);
        @(negedge clk);
        ev_frame_done = bits[0]; ev_flush_done = bits[1]; ev_pool_exhausted = bits[2];
        @(negedge clk);
        ev_frame_done = 1'b0; ev_flush_done = 1'b0; ev_pool_exhausted = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 irq", 32'(irq), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_WR: wr(VEC[i].addr, VEC[i].data);
                OP_PU: pulse(VEC[i].data[2:0]);
                default: begin
                    rd(VEC[i].addr, r);
                    check($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].data);
                end
            endcase
        end

        // R9: mask 5, pending 6 -> request active
        #1 check("R9 steady", 32'(irq), 32'h1);
        wr(A_EC, 32'h5);
        #1 check("R9 old level", 32'(irq), 32'h1);
        @(negedge clk); #1 check("R9 drop", 32'(irq), 32'h0);
        wr(A_ES, 32'h2);
        #1 check("R9 still low", 32'(irq), 32'h0);
        @(negedge clk); #1 check("R9 rise", 32'(irq), 32'h1);

        // R3 then R10: flush ack alone, then ack together with a flush pulse
        wr(A_ST, 32'h2);
        rd(A_ST, r); check("R3 flush ack", r, 32'h4);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_ST; bus_wdata = 32'h2;
        ev_flush_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; ev_flush_done = 1'b0;
        rd(A_ST, r); check("R10 event wins", r, 32'h6);

        // R1: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 irq after reset", 32'(irq), 32'h0);
        rd(A_ST, r); check("R1 pending", r, 32'h4);
        rd(A_EC, r); check("R1 mask", r, 32'h0);
        rd(A_LN, r); check("R1 length", r, 32'h0);
        rd(A_BA, r); check("R1 base", r, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule